// File: doc/BRIEF.md
# Arithmetic and Compare Coprocessor

This block is a small register-mapped helper that keeps three 32-bit operand registers and performs one step of work each time it is told to: it adds the second operand into the first, subtracts it from the first, or compares the first operand with both of the others. The operand width in use is 8, 16 or 32 bits. The result wraps at that width, and a carry or borrow out of it is recorded. Comparisons are unsigned and at the same width. Seven sticky status bits record the outcome. A set of per-bit selects, a master enable and a two-threshold window test combine them into one registered interrupt line.

Software drives the block through a simple word-addressed register port with byte enables and a one-cycle read latency. A step normally starts from a bus write to an operand register. In the two event-driven modes, a step starts instead on the rising edge of a hardware event. That event is chosen by index from an input vector, and it is ORed with two common trigger inputs, each of which can be enabled on its own.

Top module: `arith_cmp_unit`

## Requirements
- R1: After reset, the control, interrupt-select and status registers and all three operands read 0, the trigger-select register reads all ones in its event field (2^SEL_W-1, no event) with both common enables clear, and `irq` is 0.
- R2: The operands sit at word addresses 2, 3 and 4 (operand 0, 1 and 2). Each byte lane is written only when its `bus_be` bit is set, and a read returns the register on `bus_rdata` on the clock edge that follows the read request.
- R3: In add mode (control bits [2:0] = 1), a write to operand 1 makes operand 0 equal to (op0 + op1) modulo 2^w, with all bits above w cleared. A carry out of bit w-1 sets status bit 0. The result is readable one cycle later.
- R4: In subtract mode (code 2), a write to operand 1 makes operand 0 equal to (op0 - op1) modulo 2^w. Status bit 0 sets when op1 > op0 at that width.
- R5: Control bits [4:3] pick the width w: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Operand bits above w take no part in arithmetic, carry detection or comparison.
- R6: In compare mode (code 3), a compare replaces status bits [3:1] with {op0>op1, op0==op1, op0<op1} and bits [6:4] with {op0>op2, op0==op2, op0<op2}. Both comparisons are unsigned at width w.
- R7: With control bit 5 clear, only a write to operand 0 starts a compare. With bit 5 set, a write to any of the three operands starts one.
- R8: Writing ones to word address 5 clears the matching status bits, and 0x7F clears all seven. Word address 5 always reads 0.
- R9: `irq` is registered and equals control bit 6 AND the OR of (status bits AND interrupt-select bits [6:0]).
- R10: Interrupt-select bits [8:7] choose the window mode. Codes 0 and 1 use the per-bit selects. Code 2 replaces the six compare selects with "op2 <= op0 <= op1" (inside), and code 3 replaces them with "op0 > op1 or op0 < op2" (outside). The overflow select still applies in every code.
- R11: In codes 5 (add) and 6 (subtract), a step runs once per rising edge of the trigger level and never on an operand write. The trigger level is the event input chosen by trigger-select bits [SEL_W-1:0] (no event if the index is EVT_N or more), ORed with `com_trig[0]` when bit 30 is set and `com_trig[1]` when bit 31 is set.
- R12: In codes 0, 4 and 7, no operation runs and operand 0 changes only through bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (3) | Word address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | EVT_N (16) | Hardware event levels |
| com_trig | input | 2 | Common trigger levels |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with its default parameters: sixteen event inputs and a five-bit event index. With these values it can select an in-range event (index 3), an unselected neighbour, and the all-ones index that selects nothing, so the common triggers can be exercised alone. Seeded random operands across all three widths and all three operations are checked against bench models of wrap, carry, borrow and unsigned ordering. Directed cases cover the byte-lane merge, the window codes and held event levels.

// File: rtl/acu_pkg.sv
package acu_pkg;
  localparam int DW    = 32;
  localparam int NB    = DW / 8;
  localparam int NFLAG = 7;

  localparam logic [2:0] MD_IDLE  = 3'd0;
  localparam logic [2:0] MD_ADD   = 3'd1;
  localparam logic [2:0] MD_SUB   = 3'd2;
  localparam logic [2:0] MD_CMP   = 3'd3;
  localparam logic [2:0] MD_HWADD = 3'd5;
  localparam logic [2:0] MD_HWSUB = 3'd6;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;

  localparam logic [1:0] WIN_IN  = 2'd2;
  localparam logic [1:0] WIN_OUT = 2'd3;

  localparam int F_OVF = 0;
  localparam int F_LT1 = 1;
  localparam int F_EQ1 = 2;
  localparam int F_GT1 = 3;
  localparam int F_LT2 = 4;
  localparam int F_EQ2 = 5;
  localparam int F_GT2 = 6;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_FLAG = 3'd1;
  localparam logic [2:0] RA_D0   = 3'd2;
  localparam logic [2:0] RA_D1   = 3'd3;
  localparam logic [2:0] RA_D2   = 3'd4;
  localparam logic [2:0] RA_FCLR = 3'd5;
  localparam logic [2:0] RA_ISEL = 3'd6;
  localparam logic [2:0] RA_TSEL = 3'd7;

  typedef struct packed {
    logic       inten;
    logic       cmp_any;
    logic [1:0] size;
    logic [2:0] mode;
  } ctrl_t;

  function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_B:    size_mask = DW'(32'h0000_00FF);
      SZ_H:    size_mask = DW'(32'h0000_FFFF);
      default: size_mask = '1;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old,
                                               input logic [DW-1:0] wd,
                                               input logic [NB-1:0] be);
    lane_merge = old;
    for (int i = 0; i < NB; i++)
      if (be[i]) lane_merge[i*8 +: 8] = wd[i*8 +: 8];
  endfunction
endpackage

// File: rtl/acu_alu.sv
module acu_alu
  import acu_pkg::*;
(
  input  logic [1:0]    sz,
  input  logic          sub,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] op_c,
  output logic [DW-1:0] res,
  output logic          carry,
  output logic [2:0]    rel_b,
  output logic [2:0]    rel_c
);
  logic [DW-1:0] msk, am, bm, cm;
  logic [DW:0]   ext_sum, ext_dif;

  always_comb begin
    msk     = size_mask(sz);
    am      = op_a & msk;
    bm      = op_b & msk;
    cm      = op_c & msk;
    ext_sum = {1'b0, am} + {1'b0, bm};
    ext_dif = {1'b0, am} - {1'b0, bm};
    if (sub) begin
      res   = ext_dif[DW-1:0] & msk;
      carry = (am < bm);
    end else begin
      res   = ext_sum[DW-1:0] & msk;
      carry = |(ext_sum & ~{1'b0, msk});
    end
    rel_b = {am > bm, am == bm, am < bm};
    rel_c = {am > cm, am == cm, am < cm};
  end
endmodule

// File: rtl/acu_trig.sv
module acu_trig #(
  parameter int EVT_N = 16,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt_in,
  input  logic [1:0]       com_trig,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       com_en,
  output logic             rise
);
  logic lvl, lvl_q;

  always_comb begin
    lvl = |(com_trig & com_en);
    for (int i = 0; i < EVT_N; i++)
      if (sel == SEL_W'(i)) lvl = lvl | evt_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      rise  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      rise  <= lvl & ~lvl_q;
    end
  end
endmodule

// File: rtl/acu_irq.sv
module acu_irq
  import acu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] sel,
  input  logic [1:0]       win,
  input  logic             inten,
  output logic             irq
);
  logic win_hit, cmp_hit, any_hit;

  always_comb begin
    case (win)
      WIN_IN:  win_hit = (flags[F_EQ2] | flags[F_GT2]) & (flags[F_LT1] | flags[F_EQ1]);
      WIN_OUT: win_hit = flags[F_GT1] | flags[F_LT2];
      default: win_hit = 1'b0;
    endcase
    cmp_hit = win[1] ? win_hit : |(flags[NFLAG-1:1] & sel[NFLAG-1:1]);
    any_hit = (flags[F_OVF] & sel[F_OVF]) | cmp_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= inten & any_hit;
  end
endmodule

// File: rtl/arith_cmp_unit.sv
module arith_cmp_unit
  import acu_pkg::*;
#(
  parameter int EVT_N = 16,
  parameter int SEL_W = 5,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NB-1:0]    bus_be,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [EVT_N-1:0] evt_in,
  input  logic [1:0]       com_trig,
  output logic             irq
);
  localparam int ISEL_W = NFLAG + 2;

  ctrl_t             ctrl_q;
  logic [ISEL_W-1:0] isel_q;
  logic [NFLAG-1:0]  flags_q, flags_n;
  logic [DW-1:0]     d0_q, d1_q, d2_q;
  logic [SEL_W-1:0]  tsel_q;
  logic [1:0]        tcom_q;
  logic              arith_go_q, cmp_go_q;

  logic          wr, wr_d0, wr_d1, wr_d2, wr_clr;
  logic [DW-1:0] rmux, wval, alu_res;
  logic          alu_carry, hw_rise, sub_sel;
  logic [2:0]    rel1, rel2;
  logic          sw_arith, hw_arith, cmp_req;

  // Bus decode and read-modify-merge of the addressed register
  always_comb begin
    wr     = bus_en & bus_we;
    wr_d0  = wr & (bus_addr == RA_D0);
    wr_d1  = wr & (bus_addr == RA_D1);
    wr_d2  = wr & (bus_addr == RA_D2);
    wr_clr = wr & (bus_addr == RA_FCLR);
    case (bus_addr)
      RA_CTRL: rmux = DW'(ctrl_q);
      RA_FLAG: rmux = DW'(flags_q);
      RA_D0:   rmux = d0_q;
      RA_D1:   rmux = d1_q;
      RA_D2:   rmux = d2_q;
      RA_ISEL: rmux = DW'(isel_q);
      RA_TSEL: rmux = {tcom_q, {(DW-2-SEL_W){1'b0}}, tsel_q};
      default: rmux = '0;
    endcase
    wval = lane_merge(rmux, bus_wdata, bus_be);
  end

  // Step requests
  always_comb begin
    sub_sel  = (ctrl_q.mode == MD_SUB) | (ctrl_q.mode == MD_HWSUB);
    sw_arith = wr_d1 & ((ctrl_q.mode == MD_ADD) | (ctrl_q.mode == MD_SUB));
    hw_arith = hw_rise & ((ctrl_q.mode == MD_HWADD) | (ctrl_q.mode == MD_HWSUB));
    cmp_req  = (ctrl_q.mode == MD_CMP) &
               (wr_d0 | (ctrl_q.cmp_any & (wr_d1 | wr_d2)));
  end

  acu_alu u_alu (
    .sz    (ctrl_q.size),
    .sub   (sub_sel),
    .op_a  (d0_q),
    .op_b  (d1_q),
    .op_c  (d2_q),
    .res   (alu_res),
    .carry (alu_carry),
    .rel_b (rel1),
    .rel_c (rel2)
  );

  acu_trig #(.EVT_N(EVT_N), .SEL_W(SEL_W)) u_trig (
    .clk      (clk),
    .rst      (rst),
    .evt_in   (evt_in),
    .com_trig (com_trig),
    .sel      (tsel_q),
    .com_en   (tcom_q),
    .rise     (hw_rise)
  );

  // Status next state: clear first, then results of the step that completes
  always_comb begin
    flags_n = flags_q;
    if (wr_clr) flags_n = flags_n & ~wval[NFLAG-1:0];
    if (arith_go_q) flags_n[F_OVF] = flags_n[F_OVF] | alu_carry;
    if (cmp_go_q) begin
      flags_n[F_GT1:F_LT1] = rel1;
      flags_n[F_GT2:F_LT2] = rel2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      isel_q     <= '0;
      flags_q    <= '0;
      d0_q       <= '0;
      d1_q       <= '0;
      d2_q       <= '0;
      tsel_q     <= '1;
      tcom_q     <= '0;
      arith_go_q <= 1'b0;
      cmp_go_q   <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      arith_go_q <= sw_arith | hw_arith;
      cmp_go_q   <= cmp_req;
      flags_q    <= flags_n;
      if (bus_en && !bus_we) bus_rdata <= rmux;
      if (wr) begin
        case (bus_addr)
          RA_CTRL: ctrl_q <= ctrl_t'(wval[$bits(ctrl_t)-1:0]);
          RA_ISEL: isel_q <= wval[ISEL_W-1:0];
          RA_D1:   d1_q   <= wval;
          RA_D2:   d2_q   <= wval;
          RA_TSEL: begin
            tsel_q <= wval[SEL_W-1:0];
            tcom_q <= wval[DW-1:DW-2];
          end
          default: ;
        endcase
      end
      if (wr_d0)      d0_q <= wval;
      if (arith_go_q) d0_q <= alu_res;
    end
  end

  acu_irq u_irq (
    .clk   (clk),
    .rst   (rst),
    .flags (flags_q),
    .sel   (isel_q[NFLAG-1:0]),
    .win   (isel_q[ISEL_W-1:NFLAG]),
    .inten (ctrl_q.inten),
    .irq   (irq)
  );
endmodule

// File: rtl/acu_chk.sv
module acu_chk
  import acu_pkg::*;
#(
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_en,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [NB-1:0]    bus_be,
  input logic [DW-1:0]    bus_wdata,
  input logic             irq,
  input logic             inten,
  input logic [1:0]       size,
  input logic [NFLAG-1:0] flags,
  input logic [DW-1:0]    d0,
  input logic             arith_go,
  input logic             cmp_go
);
  logic wr_d0_c, clr_all_c;
  assign wr_d0_c   = bus_en && bus_we && (bus_addr == RA_D0);
  assign clr_all_c = bus_en && bus_we && (bus_addr == RA_FCLR) && bus_be[0] &&
                     (bus_wdata[NFLAG-1:0] == '1);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !inten |=> !irq);

  p_clear_all_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_all_c && !arith_go && !cmp_go) |=> (flags == '0));

  p_rel1_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags[F_GT1:F_LT1]));

  p_rel2_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flags[F_GT2:F_LT2]));

  p_byte_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (arith_go && size == SZ_B && !wr_d0_c) |=> (d0[DW-1:8] == '0));

  p_d0_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!arith_go && !wr_d0_c) |=> $stable(d0));
endmodule

bind arith_cmp_unit acu_chk #(.AW(AW)) u_acu_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .inten     (ctrl_q.inten),
  .size      (ctrl_q.size),
  .flags     (flags_q),
  .d0        (d0_q),
  .arith_go  (arith_go_q),
  .cmp_go    (cmp_go_q)
);

// File: tb/test_arith_cmp_unit.sv
module test_arith_cmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int EVT_N = 16;
  localparam int SEL_W = 5;
  localparam int AW    = 3;
  localparam logic [2:0] A_CTRL = 0, A_FLAG = 1, A_D0 = 2, A_D1 = 3, A_D2 = 4,
                         A_FCLR = 5, A_ISEL = 6, A_TSEL = 7;

  logic clk = 0, rst = 1;
  logic bus_en = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [EVT_N-1:0] evt_in = '0;
  logic [1:0] com_trig = '0;
  logic irq;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arith_cmp_unit #(.EVT_N(EVT_N), .SEL_W(SEL_W), .AW(AW)) i_arith_cmp_unit (
    .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .com_trig(com_trig), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = v; bus_be = be;
    @(negedge clk);
    bus_en = 0; bus_we = 0; bus_be = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_en = 0;
    v = bus_rdata;
  endtask

  function automatic logic [31:0] msk(input logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [32:0] arith(input logic [31:0] a, input logic [31:0] b,
                                        input logic [1:0] sz, input bit sub);
    logic [31:0] m = msk(sz);
    logic [32:0] s;
    if (sub) return {((a & m) < (b & m)), ((a & m) - (b & m)) & m};
    s = {1'b0, a & m} + {1'b0, b & m};
    return {(s > {1'b0, m}), s[31:0] & m};
  endfunction

  function automatic logic [6:0] cmpm(input logic [31:0] a, input logic [31:0] b,
                                      input logic [31:0] c, input logic [1:0] sz);
    logic [31:0] m = msk(sz);
    logic [31:0] x = a & m, y = b & m, z = c & m;
    return {x > z, x == z, x < z, x > y, x == y, x < y, 1'b0};
  endfunction

  function automatic logic [31:0] cv(input logic [2:0] md, input logic [1:0] sz,
                                     input bit any, input bit ie);
    return {25'b0, ie, any, sz, md};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [32:0] e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_FLAG, v); chk("R1 flags", v, 0);
    rd(A_D0, v);   chk("R1 op0", v, 0);
    rd(A_ISEL, v); chk("R1 isel", v, 0);
    rd(A_TSEL, v); chk("R1 tsel", v, (1 << SEL_W) - 1);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 byte lanes
    wr(A_D2, 32'hAABB_CCDD);
    wr(A_D2, 32'h1122_3344, 4'b0101);
    rd(A_D2, v); chk("R2 lanes", v, 32'hAA22_CC44);

    // R3 byte add with carry
    wr(A_CTRL, cv(1, 0, 0, 0));
    wr(A_D0, 32'hF0);
    wr(A_D1, 32'h20);
    rd(A_D0, v); chk("R3 add8 result", v, 32'h10);
    rd(A_FLAG, v); chk("R3 add8 carry", v, 1);
    wr(A_FCLR, 32'h7F);

    // R4 halfword borrow
    wr(A_CTRL, cv(2, 1, 0, 0));
    wr(A_D0, 32'h5);
    wr(A_D1, 32'h7);
    rd(A_D0, v); chk("R4 sub16 result", v, 32'hFFFE);
    rd(A_FLAG, v); chk("R4 sub16 borrow", v, 1);
    wr(A_FCLR, 32'h7F);

    // R5 upper bits ignored at byte width; 32-bit wrap
    wr(A_CTRL, cv(1, 0, 0, 0));
    wr(A_D0, 32'hABCD_0001);
    wr(A_D1, 32'hFF00_0002);
    rd(A_D0, v); chk("R5 byte ignores upper", v, 32'h3);
    rd(A_FLAG, v); chk("R5 byte no carry", v, 0);
    wr(A_CTRL, cv(1, 2, 0, 0));
    wr(A_D0, 32'hFFFF_FFFF);
    wr(A_D1, 32'h1);
    rd(A_D0, v); chk("R5 word wrap", v, 0);
    rd(A_FLAG, v); chk("R5 word carry", v, 1);
    wr(A_FCLR, 32'h7F);

    // R12 idle codes
    wr(A_CTRL, cv(0, 2, 0, 0));
    wr(A_D0, 32'h77);
    wr(A_D1, 32'h11);
    rd(A_D0, v); chk("R12 idle code0", v, 32'h77);
    wr(A_CTRL, cv(4, 2, 0, 0));
    wr(A_D1, 32'h12);
    rd(A_D0, v); chk("R12 idle code4", v, 32'h77);
    wr(A_CTRL, cv(7, 2, 1, 0));
    wr(A_D1, 32'h13);
    rd(A_D0, v); chk("R12 idle code7", v, 32'h77);
    rd(A_FLAG, v); chk("R12 no flags", v, 0);

    // R6 / R7 compare triggers
    wr(A_CTRL, cv(3, 2, 1, 0));
    wr(A_D1, 32'h100);
    wr(A_D2, 32'h10);
    wr(A_D0, 32'h100);
    rd(A_FLAG, v); chk("R6 eq1 gt2", v, cmpm(32'h100, 32'h100, 32'h10, 2));
    wr(A_D2, 32'h200);
    rd(A_FLAG, v); chk("R7 any-trigger on op2", v, cmpm(32'h100, 32'h100, 32'h200, 2));
    wr(A_CTRL, cv(3, 2, 0, 0));
    wr(A_D1, 32'h50);
    rd(A_FLAG, v); chk("R7 op1 write ignored", v, cmpm(32'h100, 32'h100, 32'h200, 2));
    wr(A_D0, 32'h100);
    rd(A_FLAG, v); chk("R7 op0 write compares", v, cmpm(32'h100, 32'h50, 32'h200, 2));

    // R8 clear
    wr(A_FCLR, 32'h08);
    rd(A_FLAG, v); chk("R8 partial clear", v, cmpm(32'h100, 32'h50, 32'h200, 2) & ~32'h08);
    wr(A_FCLR, 32'h7F);
    rd(A_FLAG, v); chk("R8 full clear", v, 0);
    rd(A_FCLR, v); chk("R8 reads zero", v, 0);

    // R9 interrupt gating
    wr(A_CTRL, cv(1, 0, 0, 0));
    wr(A_ISEL, 32'h01);
    wr(A_D0, 32'hFF);
    wr(A_D1, 32'h01);
    chk("R9 irq disabled", {31'b0, irq}, 0);
    wr(A_CTRL, cv(1, 0, 0, 1));
    wr(A_D1, 32'h00);
    chk("R9 irq enabled", {31'b0, irq}, 1);
    wr(A_FCLR, 32'h01);
    chk("R9 irq after clear", {31'b0, irq}, 0);

    // R10 window modes
    wr(A_CTRL, cv(3, 2, 1, 1));
    wr(A_ISEL, 32'h2 << 7);
    wr(A_D2, 32'd50);
    wr(A_D1, 32'd100);
    wr(A_D0, 32'd75);
    chk("R10 inside hit", {31'b0, irq}, 1);
    wr(A_ISEL, 32'h3 << 7);
    chk("R10 outside miss", {31'b0, irq}, 0);
    wr(A_D0, 32'd30);
    chk("R10 outside hit", {31'b0, irq}, 1);
    wr(A_ISEL, 32'h0);
    chk("R10 code0 no selects", {31'b0, irq}, 0);
    wr(A_ISEL, 32'h1 << 7 | 32'h10);
    chk("R10 code1 per-bit lt2", {31'b0, irq}, 1);
    wr(A_CTRL, cv(0, 2, 0, 0));
    wr(A_ISEL, 32'h0);
    wr(A_FCLR, 32'h7F);

    // R11 hardware event steps
    wr(A_TSEL, 32'd3);
    wr(A_CTRL, cv(5, 2, 0, 0));
    wr(A_D0, 32'd10);
    wr(A_D1, 32'd5);
    rd(A_D0, v); chk("R11 op1 write no step", v, 32'd10);
    @(negedge clk); evt_in[3] = 1;
    repeat (6) @(negedge clk);
    rd(A_D0, v); chk("R11 single step on held level", v, 32'd15);
    evt_in[3] = 0;
    @(negedge clk); evt_in[2] = 1;
    repeat (4) @(negedge clk); evt_in[2] = 0;
    repeat (3) @(negedge clk);
    rd(A_D0, v); chk("R11 unselected event", v, 32'd15);
    wr(A_TSEL, 32'h4000_0000 | ((1 << SEL_W) - 1));
    wr(A_CTRL, cv(6, 2, 0, 0));
    @(negedge clk); com_trig[0] = 1;
    repeat (2) @(negedge clk); com_trig[0] = 0;
    repeat (4) @(negedge clk);
    rd(A_D0, v); chk("R11 common trigger sub", v, 32'd10);
    @(negedge clk); com_trig[1] = 1;
    repeat (2) @(negedge clk); com_trig[1] = 0;
    repeat (4) @(negedge clk);
    rd(A_D0, v); chk("R11 disabled common", v, 32'd10);

    // Random sweep over R3, R4, R5, R6
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz;
      int op;
      logic [31:0] a, b, c;
      sz = 2'($urandom % 3);
      op = $urandom % 3;
      a = $urandom; b = $urandom; c = $urandom;
      if ((i % 7) == 0) b = a;
      wr(A_CTRL, cv(0, sz, 0, 0));
      wr(A_FCLR, 32'h7F);
      wr(A_D0, a);
      wr(A_D2, c);
      wr(A_D1, b);
      if (op < 2) begin
        wr(A_CTRL, cv(op == 0 ? 3'd1 : 3'd2, sz, 0, 0));
        wr(A_D1, b);
        e = arith(a, b, sz, op == 1);
        rd(A_D0, v); chk(op == 0 ? "R3 random add" : "R4 random sub", v, e[31:0]);
        rd(A_FLAG, v); chk("R5 random carry", v, {31'b0, e[32]});
      end else begin
        wr(A_CTRL, cv(3, sz, 0, 0));
        wr(A_D0, a);
        rd(A_FLAG, v); chk("R6 random compare", v, {25'b0, cmpm(a, b, c, sz)});
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule